// File: doc/BRIEF.md
# Parallel I/O Port Group

This block is one group of 24 general-purpose I/O lines arranged as three 8-bit ports, called A, B and C, plus a direction register. All four are reached through a 4-byte window on a simple byte-wide bus. The bus has a 2-bit address, write data, a write strobe, a read strobe and registered read data. The group behaves like the basic, non-handshaked mode of a classic programmable peripheral interface.

A control write with bit 7 set is a mode definition. It picks the direction of port A, of port B, and of each half of port C separately, and it clears every output latch. Each port has an output latch. The latch always appears on the pin output vector, and the matching output-enable bits are high only where a line is configured as an output. The pad tri-state driver is therefore modelled as separate output, output-enable and input vectors.

A read of a port returns, bit by bit, the pad level for lines that are inputs and the latch value for lines that are outputs.

Top module: `pio_group`

## Requirements
- R1: Reset does three things. It makes all 24 lines outputs, so `pin_oe` is 24'hFFFFFF. It clears all latches, so `pin_out` is 0. It clears `bus_rdata` to 0.
- R2: A write to offset 0, 1 or 2 loads the latch of port A, B or C. The new value is on `pin_out[7:0]`, `[15:8]` or `[23:16]` on the cycle after the write strobe. This holds whatever the port's direction is.
- R3: A write to offset 3 with data bit 7 set is a mode definition and sets the port directions, where a 1 means input. The direction bits are: bit 4 for port A, bit 1 for port B, bit 3 for port C lines 7..4, and bit 0 for port C lines 3..0. The new directions show on `pin_oe` on the next cycle.
- R4: Every mode definition clears all three output latches to zero. This includes a mode definition of 0x80, which leaves all 24 lines as outputs.
- R5: A write to offset 3 with data bit 7 clear has no effect on the directions or on the latches.
- R6: Each `pin_oe` bit is 1 exactly when its line is configured as an output.
- R7: A read strobe at offset 0, 1 or 2 captures that port into `bus_rdata` at the clock edge where the strobe is seen. Input lines return the `pin_in` level and output lines return the latch bit. Port C can be mixed by nibble.
- R8: A read of offset 3 returns the direction settings: bit 7 is 1, bits 4, 3, 1 and 0 hold the current direction bits as laid out in R3, and bits 6, 5 and 2 are 0.
- R9: `bus_rdata` keeps its value in every cycle without a read strobe, even while `pin_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Window offset: 0 port A, 1 port B, 2 port C, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Pad levels; bits 7:0 port A, 15:8 port B, 23:16 port C |
| pin_out | output | 24 | Latch values driven toward the pads, same bit layout |
| pin_oe | output | 24 | Per-line output enable, same bit layout |

## Verification
Every result of this block is due exactly one clock edge after its strobe. Latch loads, latch clears and direction changes appear on `pin_out` and `pin_oe` after the edge that sees `bus_wr`. Read data appears on `bus_rdata` after the edge that sees `bus_rd`. The bench drives strobes and `pin_in` on the falling edge, releases them on the next falling edge, and compares at that point. Each read's expected value is computed from the model state and pad levels as they stand before the capturing edge. To show that `bus_rdata` holds, the bench moves `pin_in` and idles for several cycles before comparing again.

// File: rtl/pio_pkg.sv
// Shared constants and types for the parallel I/O group.
// Assumes a fixed 4-byte window: three ports then one control byte.
package pio_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned NPORTS = 3;

    localparam logic [ADDR_W-1:0] OFS_A   = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_B   = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_C   = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_CTL = 2'd3;

    // control word bit positions (decoded by the mode register)
    localparam int unsigned CB_MODE = 7;
    localparam int unsigned CB_A    = 4;
    localparam int unsigned CB_CHI  = 3;
    localparam int unsigned CB_B    = 1;
    localparam int unsigned CB_CLO  = 0;

    // direction settings: 1 = input, 0 = output
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic chi_in;
        logic clo_in;
    } dir_t;
endpackage

// File: rtl/pio_mode_reg.sv
// Direction register. It updates only on a control write whose mode bit
// is set. Assumes the strobe is already qualified by the control offset.
module pio_mode_reg
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_data,
    output dir_t              dir,
    output logic              mode_def
);
    // mode definition pulse, also used to clear the latches
    always_comb mode_def = ctl_wr && ctl_data[CB_MODE];

    // direction state: all outputs after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= '0;
        end else if (mode_def) begin
            dir.a_in   <= ctl_data[CB_A];
            dir.b_in   <= ctl_data[CB_B];
            dir.chi_in <= ctl_data[CB_CHI];
            dir.clo_in <= ctl_data[CB_CLO];
        end
    end

    // R3: a mode definition takes its bits into the direction state
    a_r3_mode_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_data[CB_MODE]) |=>
        (dir == {$past(ctl_data[CB_A]), $past(ctl_data[CB_B]),
                 $past(ctl_data[CB_CHI]), $past(ctl_data[CB_CLO])}));

    // R5: a control write without the mode bit leaves directions alone
    a_r5_nonmode_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_data[CB_MODE]) |=> $stable(dir));
endmodule

// File: rtl/pio_port_lane.sv
// One I/O port: output latch, output enables and read value.
// The upper and lower halves take separate direction inputs. For a port
// that is not split, tie both to the same bit.
module pio_port_lane #(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              clr,
    input  logic [PORT_W-1:0] wdata,
    input  logic              hi_in,
    input  logic              lo_in,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] latch,
    output logic [PORT_W-1:0] oe,
    output logic [PORT_W-1:0] rd_val
);
    localparam int unsigned HALF = PORT_W / 2;

    // output latch: a mode definition clears it, a port write loads it
    always_ff @(posedge clk) begin
        if (!rst_n)   latch <= '0;
        else if (clr) latch <= '0;
        else if (ld)  latch <= wdata;
    end

    // per-bit enable and readback selection
    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        if (i >= HALF) begin : g_hi
            always_comb oe[i] = !hi_in;
        end else begin : g_lo
            always_comb oe[i] = !lo_in;
        end
        always_comb rd_val[i] = oe[i] ? latch[i] : pad_in[i];
    end

    // R2: a port write lands in the latch on the next cycle
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (latch == $past(wdata)));

    // R4: a mode definition empties the latch
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (latch == '0));

    // R5: without a load or clear the latch does not move
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !clr) |=> $stable(latch));
endmodule

// File: rtl/pio_read_mux.sv
// Registered read path. It captures the addressed byte on a read strobe
// and holds it otherwise.
module pio_read_mux
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] val_a,
    input  logic [BYTE_W-1:0] val_b,
    input  logic [BYTE_W-1:0] val_c,
    input  dir_t              dir,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] ctl_view;
    logic [BYTE_W-1:0] sel;

    // control byte as read back: mode bit plus direction bits
    always_comb begin
        ctl_view          = '0;
        ctl_view[CB_MODE] = 1'b1;
        ctl_view[CB_A]    = dir.a_in;
        ctl_view[CB_CHI]  = dir.chi_in;
        ctl_view[CB_B]    = dir.b_in;
        ctl_view[CB_CLO]  = dir.clo_in;
    end

    // address decode of the read source
    always_comb begin
        unique case (addr)
            OFS_A:   sel = val_a;
            OFS_B:   sel = val_b;
            OFS_C:   sel = val_c;
            default: sel = ctl_view;
        endcase
    end

    // read data register
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= sel;
    end

    // R9: read data holds without a strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    // R8: control readback has the fixed bits in place
    a_r8_ctl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == OFS_CTL) |=>
        (rdata[7] && !rdata[6] && !rdata[5] && !rdata[2]));
endmodule

// File: rtl/pio_group.sv
// Top of the 24-line parallel I/O group. It decodes the 4-byte bus window
// and wires three port lanes, the direction register and the read path.
// Assumes single-cycle strobes and a synchronous active-low reset.
module pio_group
    import pio_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [NPORTS*BYTE_W-1:0] pin_in,
    output logic [NPORTS*BYTE_W-1:0] pin_out,
    output logic [NPORTS*BYTE_W-1:0] pin_oe
);
    dir_t              dir;
    logic              mode_def;
    logic              ctl_wr;
    logic [NPORTS-1:0] port_ld;
    logic [NPORTS-1:0] hi_in;
    logic [NPORTS-1:0] lo_in;
    logic [BYTE_W-1:0] rd_val [NPORTS];

    // write decode to the control byte and the port latches
    always_comb begin
        ctl_wr = bus_wr && (bus_addr == OFS_CTL);
        for (int p = 0; p < NPORTS; p++)
            port_ld[p] = bus_wr && (bus_addr == ADDR_W'(p));
    end

    // direction fan-out: A and B whole, C by half
    always_comb begin
        hi_in = {dir.chi_in, dir.b_in, dir.a_in};
        lo_in = {dir.clo_in, dir.b_in, dir.a_in};
    end

    pio_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_data (bus_wdata),
        .dir      (dir),
        .mode_def (mode_def)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        pio_port_lane #(.PORT_W(BYTE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (port_ld[p]),
            .clr    (mode_def),
            .wdata  (bus_wdata),
            .hi_in  (hi_in[p]),
            .lo_in  (lo_in[p]),
            .pad_in (pin_in[p*BYTE_W +: BYTE_W]),
            .latch  (pin_out[p*BYTE_W +: BYTE_W]),
            .oe     (pin_oe[p*BYTE_W +: BYTE_W]),
            .rd_val (rd_val[p])
        );
    end

    pio_read_mux u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .val_a (rd_val[0]),
        .val_b (rd_val[1]),
        .val_c (rd_val[2]),
        .dir   (dir),
        .rdata (bus_rdata)
    );

    // R6: port A enables all follow one direction bit
    a_r6_a_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[7:0] == 8'h00) || (pin_oe[7:0] == 8'hFF));

    // R1: the cycle after reset all lines drive zero
    a_r1_after_reset: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '1 && pin_out == '0));
endmodule

// File: tb/tb_pio_group.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic.
module tb_pio_group;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state; direction 1 = input
    logic [7:0] m_lat [3];
    logic       m_ia, m_ib, m_ich, m_icl;
    logic [7:0] m_rd;

    always #2 clk = ~clk;

    pio_group dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [23:0] exp_oe();
        return {{4{~m_ich}}, {4{~m_icl}}, {8{~m_ib}}, {8{~m_ia}}};
    endfunction

    function automatic logic [23:0] exp_out();
        return {m_lat[2], m_lat[1], m_lat[0]};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        logic [23:0] oe;
        logic [23:0] mix;
        if (a == 2'd3) return {1'b1, 2'b00, m_ia, m_ich, 1'b0, m_ib, m_icl};
        oe  = exp_oe();
        mix = (exp_out() & oe) | (pin_in & ~oe);
        return mix[a*8 +: 8];
    endfunction

    task automatic check(input string tag, input logic [23:0] act,
                         input logic [23:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pins(input string tag);
        check({tag, " pin_out"}, pin_out, exp_out());
        check({tag, " pin_oe"}, pin_oe, exp_oe());
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a != 2'd3) m_lat[a] = d;
        else if (d[7]) begin
            m_ia = d[4]; m_ib = d[1]; m_ich = d[3]; m_icl = d[0];
            for (int p = 0; p < 3; p++) m_lat[p] = 8'h00;
        end
    endtask

    task automatic bus_read(input logic [1:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        e = exp_rd(a);
        @(negedge clk);
        bus_rd = 1'b0;
        m_rd = e;
        check(tag, {16'h0, bus_rdata}, {16'h0, e});
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < 3; p++) m_lat[p] = 8'h00;
        m_ia = 0; m_ib = 0; m_ich = 0; m_icl = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_pins("R1 reset");
        check("R1 rdata reset", {16'h0, bus_rdata}, 24'h0);

        // R2: port loads, all outputs
        bus_write(2'd0, 8'hA5); check_pins("R2 load A");
        bus_write(2'd1, 8'h3C); check_pins("R2 load B");
        bus_write(2'd2, 8'hE1); check_pins("R2 load C");
        // R7: output ports read back latches
        pin_in = 24'h5A5A5A;
        bus_read(2'd0, "R7 read out A");
        bus_read(2'd2, "R7 read out C");

        // R5: non-mode control write changes nothing
        bus_write(2'd3, 8'h1B); check_pins("R5 nonmode");
        bus_read(2'd3, "R5/R8 ctl after nonmode");

        // R4: 0x80 clears all latches, all outputs
        bus_write(2'd3, 8'h80); check_pins("R4 clear 0x80");

        // R3/R6: all inputs
        bus_write(2'd0, 8'hFF);
        bus_write(2'd3, 8'h9B); check_pins("R3 all input");
        bus_read(2'd3, "R8 ctl all input");
        pin_in = 24'hC3_96_71;
        bus_read(2'd1, "R7 read pins B");
        // R2: a write to an input port still loads the latch
        bus_write(2'd1, 8'h77); check_pins("R2 load input B");
        bus_read(2'd1, "R7 input B ignores latch");

        // R3/R7: mixed port C, upper input lower output
        bus_write(2'd3, 8'h88);
        bus_write(2'd2, 8'h0F); check_pins("R3 C upper input");
        pin_in = 24'hA0_00_00;
        bus_read(2'd2, "R7 C mixed hi-in");
        bus_write(2'd3, 8'h81);
        bus_write(2'd2, 8'hF0); check_pins("R3 C lower input");
        pin_in = 24'h05_00_00;
        bus_read(2'd2, "R7 C mixed lo-in");

        // R9: read data holds while pads move
        pin_in = 24'hFFFFFF;
        repeat (4) @(negedge clk);
        check("R9 rdata hold", {16'h0, bus_rdata}, {16'h0, m_rd});

        // random traffic
        for (int k = 0; k < 400; k++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            pin_in = 24'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                bus_write(a, d);
                check_pins("R2/R3/R4/R5/R6 random write");
            end else begin
                bus_read(a, "R7/R8 random read");
            end
        end

        // R1: reset again from a busy state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int p = 0; p < 3; p++) m_lat[p] = 8'h00;
        m_ia = 0; m_ib = 0; m_ich = 0; m_icl = 0;
        check_pins("R1 re-reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule